// File: doc/BRIEF.md
# Four-Channel DAC Write and Update Controller

This block sits between a byte-wide register bus and a four-channel serial D/A converter. Software fills a holding byte with the low data bits, then writes a control byte that carries the upper data bits, a channel number and two mode bits. The control write either sends one 24-bit serial frame to the converter or, in capture mode, hands the 12-bit code to a waveform store without touching the converter.

A second pair of data registers gives a one-shot alternate source. Writing its high byte arms it, and the next accepted control write takes its data from that pair instead of the primary pair. A frame can be sent as "latch only", which loads the channel without changing its output, or as "commit", which updates every latched channel. A read of the update address raises a one-cycle strobe that makes the converter switch all channels to their loaded values. A busy flag covers each transfer. A control write that arrives during a transfer is dropped and recorded in a sticky collision flag.

Top module: `dac_upd_top`

## Requirements
- R1: A write to the primary low register (addr 0) only stores the byte: no frame starts (csN stays 1) and busy stays 0.
- R2: A control write (addr 1; bits [3:0] data[11:8], bits [5:4] channel, bit 6 simultaneous, bit 7 capture) accepted while idle sends one frame {cmd[3:0], 2'b00, channel[1:0], data[11:0], 4'b0000}, MSB first. csN is low for the whole frame, sclk idles high, sdo changes only when sclk falls, and the converter samples on the rising sclk. cmd is 4'h2 (commit: update all latched channels) when the simultaneous bit is 0.
- R3: With enhEn=1 and the simultaneous bit at 1, cmd is 4'h0 (latch only).
- R4: With enhEn=0, the simultaneous and capture bits are read as 0. Every control write then sends a commit frame and capValid stays 0.
- R5: With enhEn=1 and the capture bit at 1, no frame is sent and busy stays 0. For exactly one cycle after the write, capValid is 1 with capCode = the 12-bit code and capChan = the channel.
- R6: A write to the alternate high register (addr 3, bits [3:0] = data[11:8]) arms the alternate source. The next accepted control write uses {alt high, alt low (addr 2)} as data and disarms it. Later writes use the primary pair again.
- R7: A read strobe at addr 4 gives updAll = 1 for one cycle, in the cycle after the read, and starts no frame.
- R8: busy is 0 after reset, becomes 1 in the cycle after an accepted control write, and stays 1 until the frame has ended.
- R9: A control write while busy is dropped: no frame results and the alternate arm is not consumed. collision becomes 1 and stays 1 until reset.
- R10: After reset: csN=1, sclk=1, busy=0, collision=0, updAll=0, capValid=0.
- R11: Each frame contains exactly 24 rising sclk edges while csN is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enhEn | input | 1 | Enables the simultaneous and capture mode bits |
| wrEn | input | 1 | Bus write strobe |
| rdEn | input | 1 | Bus read strobe |
| addr | input | 3 | Register address |
| wrData | input | 8 | Bus write data |
| busy | output | 1 | A serial transfer is in progress |
| collision | output | 1 | Sticky flag: a control write was dropped while busy |
| sclk | output | 1 | Serial clock to the converter |
| csN | output | 1 | Active-low frame select |
| sdo | output | 1 | Serial data to the converter |
| updAll | output | 1 | One-cycle strobe: all channels take their loaded values |
| capValid | output | 1 | Captured code is valid |
| capChan | output | 2 | Channel of the captured code |
| capCode | output | 12 | Captured 12-bit code |

## Verification
A wrong alternate arm or a wrong source choice shows up in the data field of the next frame, one full frame time after the write. A wrong mode decode shows up in the command nibble or in a frame that is missing or extra. A busy flag that clears too early lets a colliding write through, and the serial monitor then sees an extra or corrupted frame at csN's rising edge. The capture and update strobes are visible one cycle after their bus access.

// File: rtl/dac_upd_pkg.sv
package dac_upd_pkg;
  localparam int DATA_W   = 12;
  localparam int CH_W     = 2;
  localparam int CMD_W    = 4;
  localparam int CHFLD_W  = 4;
  localparam int SLOT_W   = 16;
  localparam int FRAME_W  = CMD_W + CHFLD_W + SLOT_W;
  localparam int BYTE_W   = 8;
  localparam int HI_BITS  = DATA_W - BYTE_W;
  localparam int ADDR_W   = 3;

  // control byte field positions
  localparam int HB_CH_LSB = 4;
  localparam int HB_SIM    = 6;
  localparam int HB_CAP    = 7;

  localparam logic [CMD_W-1:0] CMD_LATCH  = 4'h0;
  localparam logic [CMD_W-1:0] CMD_COMMIT = 4'h2;

  localparam logic [ADDR_W-1:0] A_LO     = 3'd0;
  localparam logic [ADDR_W-1:0] A_HI     = 3'd1;
  localparam logic [ADDR_W-1:0] A_ALT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_ALT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_UPD    = 3'd4;

  typedef struct packed {
    logic               loadFrame;
    logic [FRAME_W-1:0] frame;
  } dpCmd_t;
endpackage

// File: rtl/dac_upd_ctrl.sv
module dac_upd_ctrl
  import dac_upd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enhEn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              frameDone,
  output dpCmd_t            dpCmd,
  output logic              busy,
  output logic              collision,
  output logic              updAll,
  output logic              capValid,
  output logic [CH_W-1:0]   capChan,
  output logic [DATA_W-1:0] capCode
);
  logic [BYTE_W-1:0]  loByte, altLo;
  logic [HI_BITS-1:0] altHi;
  logic               altArmed;
  logic [DATA_W-1:0]  code;
  logic [CH_W-1:0]    chSel;
  logic               simEff, capEff;
  logic [CMD_W-1:0]   cmd;

  always_comb begin
    code   = altArmed ? {altHi, altLo} : {wrData[HI_BITS-1:0], loByte};
    chSel  = wrData[HB_CH_LSB +: CH_W];
    simEff = enhEn & wrData[HB_SIM];
    capEff = enhEn & wrData[HB_CAP];
    cmd    = simEff ? CMD_LATCH : CMD_COMMIT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loByte    <= '0;
      altLo     <= '0;
      altHi     <= '0;
      altArmed  <= 1'b0;
      busy      <= 1'b0;
      collision <= 1'b0;
      updAll    <= 1'b0;
      capValid  <= 1'b0;
      capChan   <= '0;
      capCode   <= '0;
      dpCmd     <= '0;
    end else begin
      dpCmd.loadFrame <= 1'b0;
      capValid        <= 1'b0;
      updAll          <= rdEn && (addr == A_UPD);
      if (frameDone) busy <= 1'b0;
      if (wrEn) begin
        unique case (addr)
          A_LO:     loByte <= wrData;
          A_ALT_LO: altLo  <= wrData;
          A_ALT_HI: begin
            altHi    <= wrData[HI_BITS-1:0];
            altArmed <= 1'b1;
          end
          A_HI: begin
            if (busy) begin
              collision <= 1'b1;
            end else begin
              altArmed <= 1'b0;
              if (capEff) begin
                capValid <= 1'b1;
                capChan  <= chSel;
                capCode  <= code;
              end else begin
                busy            <= 1'b1;
                dpCmd.loadFrame <= 1'b1;
                dpCmd.frame     <= {cmd, {(CHFLD_W-CH_W){1'b0}}, chSel,
                                    code, {(SLOT_W-DATA_W){1'b0}}};
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dac_upd_datapath.sv
module dac_upd_datapath
  import dac_upd_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  dpCmd_t dpCmd,
  output logic   sclk,
  output logic   csN,
  output logic   sdo,
  output logic   frameDone
);
  localparam int DIV_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int BIT_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] shiftReg;
  logic [BIT_W-1:0]   bitCnt;
  logic [DIV_W-1:0]   divCnt;
  logic               active;

  assign csN = ~active;
  assign sdo = active & shiftReg[FRAME_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      bitCnt    <= '0;
      divCnt    <= '0;
      active    <= 1'b0;
      sclk      <= 1'b1;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      if (!active) begin
        if (dpCmd.loadFrame) begin
          shiftReg <= dpCmd.frame;
          bitCnt   <= '0;
          divCnt   <= '0;
          active   <= 1'b1;
          sclk     <= 1'b0;
        end
      end else if (divCnt == DIV_W'(HALF_CYC - 1)) begin
        divCnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
        end else if (bitCnt == BIT_W'(FRAME_W - 1)) begin
          active    <= 1'b0;
          frameDone <= 1'b1;
        end else begin
          sclk     <= 1'b0;
          shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
          bitCnt   <= bitCnt + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dac_upd_top.sv
module dac_upd_top
  import dac_upd_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enhEn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  output logic              busy,
  output logic              collision,
  output logic              sclk,
  output logic              csN,
  output logic              sdo,
  output logic              updAll,
  output logic              capValid,
  output logic [CH_W-1:0]   capChan,
  output logic [DATA_W-1:0] capCode
);
  dpCmd_t dpCmd;
  logic   frameDone;

  dac_upd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enhEn(enhEn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .frameDone(frameDone), .dpCmd(dpCmd),
    .busy(busy), .collision(collision), .updAll(updAll),
    .capValid(capValid), .capChan(capChan), .capCode(capCode)
  );

  dac_upd_datapath #(.HALF_CYC(HALF_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .dpCmd(dpCmd), .sclk(sclk), .csN(csN),
    .sdo(sdo), .frameDone(frameDone)
  );
endmodule

// File: rtl/dac_upd_checker.sv
module dac_upd_checker (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic collision,
  input logic csN,
  input logic sclk,
  input logic sdo,
  input logic capValid
);
  AST_CS_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> busy); // R8

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sclk); // R2

  AST_SDO_HELD_ON_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && sclk && $past(sclk) && !$past(csN)) |-> $stable(sdo)); // R2

  AST_CAPTURE_NO_TRANSFER: assert property (@(posedge clk) disable iff (!rstN)
    capValid |-> (!busy && csN)); // R5

  AST_COLLISION_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    collision |=> collision); // R9

  AST_COLLISION_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(collision) |-> $past(busy)); // R9
endmodule

bind dac_upd_top dac_upd_checker u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .collision(collision),
  .csN(csN), .sclk(sclk), .sdo(sdo), .capValid(capValid)
);

// File: tb/tb_dac_upd_top.sv
`timescale 1ns/1ps
module tb_dac_upd_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enhEn = 1'b1;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic        busy, collision, sclk, csN, sdo, updAll, capValid;
  logic [1:0]  capChan;
  logic [11:0] capCode;

  always #2 clk = ~clk;

  dac_upd_top #(.HALF_CYC(2)) dut (
    .clk(clk), .rstN(rstN), .enhEn(enhEn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .busy(busy), .collision(collision),
    .sclk(sclk), .csN(csN), .sdo(sdo), .updAll(updAll),
    .capValid(capValid), .capChan(capChan), .capCode(capCode)
  );

  int checks = 0;
  int errors = 0;
  logic [23:0] expQ[$];

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] frm(input logic [3:0] cmd,
                                      input logic [1:0] ch,
                                      input logic [11:0] d);
    return {cmd, 2'b00, ch, d, 4'h0};
  endfunction

  // scoreboard monitor: converter model
  logic [23:0] rxShift = '0;
  int          rxBits = 0;
  bit          inFrame = 0;

  always @(negedge csN) begin
    inFrame = 1;
    rxBits  = 0;
  end

  always @(posedge sclk) begin
    if (inFrame && csN === 1'b0) begin
      rxShift = {rxShift[22:0], sdo};
      rxBits++;
    end
  end

  always @(posedge csN) begin
    if (inFrame) begin
      inFrame = 0;
      if (expQ.size() == 0) begin
        chk(1'b0, "R1/R9 unexpected frame", {8'h0, rxShift}, 32'h0);
      end else begin
        logic [23:0] e;
        e = expQ.pop_front();
        chk(rxShift == e, "R2 frame content", {8'h0, rxShift}, {8'h0, e});
      end
      chk(rxBits == 24, "R11 sclk edges per frame", rxBits, 24);
    end
  end

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (busy);
    repeat (3) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(csN == 1 && sclk == 1 && busy == 0 && collision == 0 &&
        updAll == 0 && capValid == 0, "R10 reset state",
        {csN, sclk, busy, collision, updAll, capValid}, 6'b110000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: a low byte write alone starts nothing
    busWrite(3'd0, 8'h5A);
    repeat (20) @(negedge clk);
    chk(csN == 1 && busy == 0, "R1 low write only holds", {csN, busy}, 2'b10);

    // R2, R8: commit frame on channel 2
    busWrite(3'd0, 8'h34);
    expQ.push_back(frm(4'h2, 2'd2, 12'hC34));
    busWrite(3'd1, 8'h2C);
    chk(busy == 1, "R8 busy after accepted write", busy, 1);
    waitIdle();
    chk(busy == 0, "R8 busy clears after frame", busy, 0);

    // R3: latch-only command
    busWrite(3'd0, 8'h11);
    expQ.push_back(frm(4'h0, 2'd1, 12'h711));
    busWrite(3'd1, 8'h57);
    waitIdle();

    // R4: mode bits ignored when enhanced features are off
    enhEn = 1'b0;
    expQ.push_back(frm(4'h2, 2'd3, 12'h911));
    busWrite(3'd1, 8'h79);
    waitIdle();
    expQ.push_back(frm(4'h2, 2'd0, 12'hA11));
    busWrite(3'd1, 8'h8A);
    chk(capValid == 0, "R4 capture forced off", capValid, 0);
    chk(busy == 1, "R4 capture-off write still transfers", busy, 1);
    waitIdle();
    enhEn = 1'b1;

    // R5: capture mode
    busWrite(3'd0, 8'hEE);
    busWrite(3'd1, 8'hA3);
    chk(capValid == 1, "R5 capValid pulse", capValid, 1);
    chk(capCode == 12'h3EE, "R5 capCode", capCode, 12'h3EE);
    chk(capChan == 2'd2, "R5 capChan", capChan, 2);
    chk(busy == 0, "R5 no transfer on capture", busy, 0);
    @(negedge clk);
    chk(capValid == 0, "R5 capValid single cycle", capValid, 0);
    repeat (20) @(negedge clk);

    // R6: alternate source is one-shot
    busWrite(3'd2, 8'h99);
    busWrite(3'd3, 8'h05);
    busWrite(3'd0, 8'h12);
    expQ.push_back(frm(4'h2, 2'd1, 12'h599));
    busWrite(3'd1, 8'h1F);
    waitIdle();
    expQ.push_back(frm(4'h2, 2'd1, 12'hF12));
    busWrite(3'd1, 8'h1F);
    waitIdle();

    // R7: update-all read
    busRead(3'd4);
    chk(updAll == 1, "R7 updAll pulse", updAll, 1);
    @(negedge clk);
    chk(updAll == 0, "R7 updAll single cycle", updAll, 0);
    chk(csN == 1 && busy == 0, "R7 no frame on update", {csN, busy}, 2'b10);

    // R9: collision while busy keeps the alternate arm
    chk(collision == 0, "R9 collision clear before", collision, 0);
    busWrite(3'd0, 8'h00);
    expQ.push_back(frm(4'h2, 2'd0, 12'h100));
    busWrite(3'd1, 8'h01);
    busWrite(3'd2, 8'h77);
    busWrite(3'd3, 8'h06);
    busWrite(3'd1, 8'h3F);
    chk(collision == 1, "R9 collision set", collision, 1);
    waitIdle();
    expQ.push_back(frm(4'h2, 2'd3, 12'h677));
    busWrite(3'd1, 8'h32);
    waitIdle();
    chk(collision == 1, "R9 collision sticky", collision, 1);

    chk(expQ.size() == 0, "R2 all expected frames seen", expQ.size(), 0);
    finishRun();
  end
endmodule